// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block watches three 8-line general-purpose input ports, named A, B and F, and turns pin activity into interrupt requests. Every line has its own trigger setting. One bit picks level or edge detection, and a second bit picks the active sense: high/rising or low/falling. Each line also has an enable bit and an optional debounce filter. Edge events are held in a pending latch until software clears them with a write-one end-of-interrupt. Level events follow the qualified pin for as long as the level lasts.

Software reaches the block through a byte-wide register port: an address, a write strobe, write data and registered read data. Ports A and B share one combined interrupt output. Each of the eight port F lines has an interrupt output of its own. Pins are synchronised into the clock domain before detection. The debounce filter runs on a shared sample tick and accepts a new level only after it has held steady for a configurable number of ticks.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Pin n of a port (n = 0..7) maps to bit n of every register of that port. Line number L belongs to port L/8 (A=0, B=1, F=2) at bit L mod 8.
- R2: In the mode register, a bit value of 0 makes the line level-sensitive and 1 makes it edge-sensitive.
- R3: In the sense register, a bit value of 0 selects active-low or falling edge, and 1 selects active-high or rising edge.
- R4: The registers sit at these addresses, listed for A/B/F:
  - mode: 0x90/0xAC/0x4C
  - sense: 0x94/0xB0/0x50
  - end-of-interrupt (write only): 0x98/0xB4/0x54
  - enable: 0x9C/0xB8/0x58
  - status (read only): 0xA0/0xBC/0x5C
  - debounce: 0xA8/0xC4/0x64
  All readable registers read back what was last written.
- R5: A write to end-of-interrupt clears the edge pending bit at every position written as 1. Positions written as 0 keep their value.
- R6: A line with enable 0 neither reports status nor raises an interrupt. An edge that occurs while the line is disabled is not latched, so setting enable afterwards reports nothing.
- R7: With debounce on for a line, a pin pulse shorter than DB_COUNT sample ticks (one tick every DB_DIV clocks) is ignored. A level held longer than that is accepted. With debounce off, a two-clock pulse is detected.
- R8: irq_ab is the registered OR of the enabled pending bits of ports A and B. irq_f[n] is the registered enabled pending bit of port F line n.
- R9: A level-mode pending bit stays set while its level persists, even across an end-of-interrupt write. It drops once the pin leaves the active level.
- R10: All registers and outputs reset to 0. Status reads pending AND enable. rd_data shows the register at bus_addr one clock after the address is presented.
- R11: A pin change reaches the status after two clock edges of synchronisation. A level-mode interrupt output changes on the third clock edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | LINES | Write data |
| rd_data | output | LINES | Registered read data for bus_addr |
| pin_a | input | LINES | Port A pins |
| pin_b | input | LINES | Port B pins |
| pin_f | input | LINES | Port F pins |
| irq_ab | output | 1 | Combined interrupt of ports A and B |
| irq_f | output | LINES | Per-line interrupts of port F |

## Verification
The bench builds the block with LINES=8, DB_DIV=2 and DB_COUNT=4, so a debounced line needs eight steady clocks before it is accepted. With these values, a three-clock pulse that must be rejected and a long hold that must be accepted both fit in a few dozen cycles. The two-clock sample tick also means a rejected pulse can span tick boundaries and still leave the counter short of its limit. The same short pulse on an unfiltered line shows that the filter is applied per line.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int NPORT = 3;
  localparam int AW    = 8;

  // port order: A, B, F
  localparam logic [AW-1:0] ADDR_MODE [NPORT] = '{8'h90, 8'hAC, 8'h4C};
  localparam logic [AW-1:0] ADDR_SENSE[NPORT] = '{8'h94, 8'hB0, 8'h50};
  localparam logic [AW-1:0] ADDR_EOI  [NPORT] = '{8'h98, 8'hB4, 8'h54};
  localparam logic [AW-1:0] ADDR_EN   [NPORT] = '{8'h9C, 8'hB8, 8'h58};
  localparam logic [AW-1:0] ADDR_STAT [NPORT] = '{8'hA0, 8'hBC, 8'h5C};
  localparam logic [AW-1:0] ADDR_DB   [NPORT] = '{8'hA8, 8'hC4, 8'h64};
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      dout <= '0;
    end else begin
      meta <= din;
      dout <= meta;
    end
  end
endmodule

// File: rtl/gpio_irq_debounce.sv
module gpio_irq_debounce #(
  parameter int W        = 8,
  parameter int DB_COUNT = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] din,
  output logic [W-1:0] filt
);
  localparam int CW = (DB_COUNT > 2) ? $clog2(DB_COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(DB_COUNT - 1);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt     <= '0;
        filt[i] <= 1'b0;
      end else if (din[i] == filt[i]) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == LAST) begin
          filt[i] <= din[i];
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R7
  filt_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(filt));

  // R7
  filt_follows_input_chk: assert property (@(posedge clk) disable iff (rst)
    ((filt ^ $past(filt)) & (filt ^ $past(din))) == '0);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int LINES    = 8,
  parameter int DB_COUNT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [LINES-1:0] pin_in,
  input  logic             wr_mode,
  input  logic             wr_sense,
  input  logic             wr_en,
  input  logic             wr_db,
  input  logic             wr_eoi,
  input  logic [LINES-1:0] wdata,
  output logic [LINES-1:0] mode_q,
  output logic [LINES-1:0] sense_q,
  output logic [LINES-1:0] en_q,
  output logic [LINES-1:0] db_q,
  output logic [LINES-1:0] status
);
  logic [LINES-1:0] synced, filtered, qual, prev, rise, fall;
  logic [LINES-1:0] hit_edge, set_pend, edge_pend, lvl_hit, pending, eoi_mask;

  gpio_irq_sync #(.W(LINES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .dout(synced));

  gpio_irq_debounce #(.W(LINES), .DB_COUNT(DB_COUNT)) u_db (
    .clk(clk), .rst(rst), .tick(tick), .din(synced), .filt(filtered));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      sense_q <= '0;
      en_q    <= '0;
      db_q    <= '0;
    end else begin
      if (wr_mode)  mode_q  <= wdata;
      if (wr_sense) sense_q <= wdata;
      if (wr_en)    en_q    <= wdata;
      if (wr_db)    db_q    <= wdata;
    end
  end

  always_comb begin
    qual     = (db_q & filtered) | (~db_q & synced);
    rise     = qual & ~prev;
    fall     = ~qual & prev;
    hit_edge = (sense_q & rise) | (~sense_q & fall);
    set_pend = hit_edge & mode_q & en_q;
    lvl_hit  = ~(qual ^ sense_q);
    eoi_mask = wr_eoi ? wdata : '0;
    pending  = (mode_q & edge_pend) | (~mode_q & lvl_hit);
    status   = pending & en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev      <= '0;
      edge_pend <= '0;
    end else begin
      prev      <= qual;
      edge_pend <= (edge_pend & ~eoi_mask) | set_pend;
    end
  end

  // R5
  eoi_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_eoi |=> ((edge_pend & $past(wdata) & ~$past(set_pend)) == '0));

  // R6
  no_latch_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((edge_pend & ~$past(edge_pend) & ~$past(en_q)) == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int LINES    = 8,
  parameter int DB_DIV   = 2,
  parameter int DB_COUNT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [LINES-1:0] bus_wdata,
  output logic [LINES-1:0] rd_data,
  input  logic [LINES-1:0] pin_a,
  input  logic [LINES-1:0] pin_b,
  input  logic [LINES-1:0] pin_f,
  output logic             irq_ab,
  output logic [LINES-1:0] irq_f
);
  localparam int TW = (DB_DIV > 2) ? $clog2(DB_DIV) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(DB_DIV - 1);

  logic [LINES-1:0] pins    [NPORT];
  logic [LINES-1:0] mode_r  [NPORT];
  logic [LINES-1:0] sense_r [NPORT];
  logic [LINES-1:0] en_r    [NPORT];
  logic [LINES-1:0] db_r    [NPORT];
  logic [LINES-1:0] stat_r  [NPORT];
  logic [LINES-1:0] rd_next;
  logic [TW-1:0]    tick_cnt;
  logic             tick;

  assign pins[0] = pin_a;
  assign pins[1] = pin_b;
  assign pins[2] = pin_f;

  always_ff @(posedge clk) begin
    if (rst) tick_cnt <= '0;
    else if (tick) tick_cnt <= '0;
    else tick_cnt <= tick_cnt + 1'b1;
  end
  assign tick = (tick_cnt == TICK_LAST);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    gpio_irq_port #(.LINES(LINES), .DB_COUNT(DB_COUNT)) u_port (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .pin_in  (pins[p]),
      .wr_mode (bus_wr && bus_addr == ADDR_MODE[p]),
      .wr_sense(bus_wr && bus_addr == ADDR_SENSE[p]),
      .wr_en   (bus_wr && bus_addr == ADDR_EN[p]),
      .wr_db   (bus_wr && bus_addr == ADDR_DB[p]),
      .wr_eoi  (bus_wr && bus_addr == ADDR_EOI[p]),
      .wdata   (bus_wdata),
      .mode_q  (mode_r[p]),
      .sense_q (sense_r[p]),
      .en_q    (en_r[p]),
      .db_q    (db_r[p]),
      .status  (stat_r[p])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (bus_addr == ADDR_MODE[p])  rd_next = mode_r[p];
      if (bus_addr == ADDR_SENSE[p]) rd_next = sense_r[p];
      if (bus_addr == ADDR_EN[p])    rd_next = en_r[p];
      if (bus_addr == ADDR_DB[p])    rd_next = db_r[p];
      if (bus_addr == ADDR_STAT[p])  rd_next = stat_r[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq_ab  <= 1'b0;
      irq_f   <= '0;
    end else begin
      rd_data <= rd_next;
      irq_ab  <= (|stat_r[0]) | (|stat_r[1]);
      irq_f   <= stat_r[2];
    end
  end

  // R8
  irq_ab_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (en_r[0] == '0 && en_r[1] == '0) |=> !irq_ab);

  // R6
  irq_f_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_f & ~$past(en_r[2])) == '0));
endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [7:0]       bus_addr = '0;
  logic             bus_wr = 1'b0;
  logic [LINES-1:0] bus_wdata = '0;
  logic [LINES-1:0] rd_data;
  logic [LINES-1:0] pin_a = '0, pin_b = '0, pin_f = '0;
  logic             irq_ab;
  logic [LINES-1:0] irq_f;

  int n_chk = 0, n_fail = 0;
  logic [LINES-1:0] exp_q[$];
  string            tag_q[$];
  logic             rd_req = 1'b0, mon_flag = 1'b0;

  gpio_irq_ctrl #(.LINES(LINES), .DB_DIV(2), .DB_COUNT(4)) u_gpio_irq_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .pin_a(pin_a), .pin_b(pin_b),
    .pin_f(pin_f), .irq_ab(irq_ab), .irq_f(irq_f));

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) mon_flag <= rd_req;

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (mon_flag && exp_q.size() > 0) begin
      logic [LINES-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rd_data !== e) begin
        n_fail++;
        $display("FAIL %s read actual=%h expected=%h", t, rd_data, e);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    bus_addr = a; rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] e, input string t);
    n_chk++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", t, act, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(2);
    // reset state
    rd_expect(8'hA0, 8'h00, "R10 status A reset");
    rd_expect(8'h90, 8'h00, "R10 mode A reset");
    chk({7'd0, irq_ab}, 8'h00, "R10 irq_ab reset");
    chk(irq_f, 8'h00, "R10 irq_f reset");

    // port A rising edge on line 0
    wr(8'h90, 8'hFF);
    wr(8'h94, 8'hFF);
    wr(8'h9C, 8'h01);
    rd_expect(8'h90, 8'hFF, "R4 mode A readback");
    rd_expect(8'h9C, 8'h01, "R4 enable A readback");
    pin_a[0] = 1'b1;
    cyc(6);
    rd_expect(8'hA0, 8'h01, "R2 R3 rising edge latched");
    chk({7'd0, irq_ab}, 8'h01, "R8 irq_ab on port A");
    pin_a[0] = 1'b0;
    cyc(6);
    rd_expect(8'hA0, 8'h01, "R2 edge held after pin drop");
    wr(8'h98, 8'h02);
    rd_expect(8'hA0, 8'h01, "R5 eoi zero bit keeps pending");
    wr(8'h98, 8'h01);
    rd_expect(8'hA0, 8'h00, "R5 eoi one bit clears");
    cyc(2);
    chk({7'd0, irq_ab}, 8'h00, "R8 irq_ab cleared");

    // edge while disabled is not latched
    pin_a[1] = 1'b1;
    cyc(6);
    rd_expect(8'hA0, 8'h00, "R6 disabled line silent");
    wr(8'h9C, 8'h03);
    cyc(3);
    rd_expect(8'hA0, 8'h00, "R6 no late report after enable");

    // port B falling edge on line 4
    wr(8'hAC, 8'hFF);
    wr(8'hB0, 8'h00);
    wr(8'hB8, 8'h10);
    pin_b[4] = 1'b1;
    cyc(6);
    rd_expect(8'hBC, 8'h00, "R3 rising ignored in falling mode");
    pin_b[4] = 1'b0;
    cyc(6);
    rd_expect(8'hBC, 8'h10, "R1 R3 falling edge on B line 4");
    chk({7'd0, irq_ab}, 8'h01, "R8 irq_ab on port B");
    wr(8'hB4, 8'h10);
    rd_expect(8'hBC, 8'h00, "R5 port B eoi");

    // port F level mode
    wr(8'h50, 8'h04);
    wr(8'h58, 8'h0C);
    cyc(4);
    rd_expect(8'h5C, 8'h08, "R2 R3 active-low level");
    chk(irq_f, 8'h08, "R8 irq_f per line");
    @(negedge clk);
    pin_f[2] = 1'b1;
    @(negedge clk);
    chk(irq_f, 8'h08, "R11 no change after one edge");
    @(negedge clk);
    chk(irq_f, 8'h08, "R11 no change after two edges");
    @(negedge clk);
    chk(irq_f, 8'h0C, "R11 change after three edges");
    wr(8'h54, 8'h08);
    rd_expect(8'h5C, 8'h0C, "R9 level survives eoi");
    pin_f[3] = 1'b1;
    cyc(5);
    rd_expect(8'h5C, 8'h04, "R9 level drops with pin");

    // debounce on line 0, none on line 1
    wr(8'h64, 8'h01);
    wr(8'h50, 8'h07);
    wr(8'h4C, 8'h03);
    wr(8'h58, 8'h07);
    rd_expect(8'h64, 8'h01, "R4 debounce readback");
    cyc(3);
    rd_expect(8'h5C, 8'h04, "R7 start state");
    @(negedge clk);
    pin_f[1] = 1'b1;
    cyc(2);
    pin_f[1] = 1'b0;
    cyc(6);
    rd_expect(8'h5C, 8'h06, "R7 short pulse seen without debounce");
    pin_f[0] = 1'b1;
    cyc(3);
    pin_f[0] = 1'b0;
    cyc(20);
    rd_expect(8'h5C, 8'h06, "R7 short pulse filtered");
    pin_f[0] = 1'b1;
    cyc(30);
    rd_expect(8'h5C, 8'h07, "R7 stable level accepted");
    chk(irq_f, 8'h07, "R7 R8 irq_f after debounce");

    cyc(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule